// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves one byte at a time through an 8-bit shift register, sending on a serial data output and receiving on a serial data input in the same transfer. A 4-bit control register holds four settings. One bit holds the port idle or lets it run. One bit decides whether the port drives the serial clock line or follows an external clock on it. Two bits pick which of four sources sets the clock rate when the port drives the line. Software places a byte in the transmit buffer, which raises a ready flag. Once the port is running, it shifts eight bits, leaves the received byte in the receive buffer, clears the ready flag and pulses a done strobe.

When the port drives the clock, the shift clock runs at half the rate of rising edges on the selected source. The sources are the system clock, a timer-1 output, a prescaler output and a timer-2 toggle output. When the port follows the line, the select bits have no effect. A separate mode input turns on two-wire behaviour. In that mode, writing the halt bit low sends a start condition and writing it high sends a stop condition. In the ordinary synchronous mode, writing the halt bit high instead copies the shift register into the receive buffer.

Top module: `ssp_core`

## Requirements
- R1: After reset, the control register reads 4'b1111, tx_rdy is 0, rx_data is 0, sdo is 1, sclk_out is 1, sclk_oe is 1 and xfer_done is 0.
- R2: While control bit 3 (halt) is 1, no transfer runs. sclk_out stays 1, xfer_done stays 0, and a loaded byte keeps tx_rdy at 1.
- R3: A tx_load pulse stores tx_data and sets tx_rdy. A transfer starts only when halt is 0, tx_rdy is 1 and no two-wire condition is in progress.
- R4: Data leaves most significant bit first. sdo changes only on falling shift-clock edges, and sdi is sampled on rising edges. After a full transfer, rx_data holds the eight sampled bits, the first one in bit 7.
- R5: After the eighth falling shift-clock edge, the port stops clocking, clears tx_rdy and raises xfer_done for exactly one cycle.
- R6: With control bit 2 (drive) at 1, bits 1:0 pick the source: 11 system clock, 10 timer-1 output, 01 prescaler output, 00 timer-2 toggle. One shift-clock period spans two rising edges of that source. On the system clock, xfer_done appears 17 cycles after the tx_load edge.
- R7: With drive at 0, sclk_oe is 0 outside two-wire conditions and shifting follows edges on sclk_in. Bits 1:0 are then ignored, so nothing shifts without sclk_in edges.
- R8: With drive at 1, sclk_oe is 1, and sclk_out rests at 1 between transfers.
- R9: In synchronous mode (twowire_en = 0), writing 1 to halt copies the present shift register into rx_data and ends any transfer without xfer_done.
- R10: In two-wire mode, writing halt = 0 gives a start condition (sdo 1 then 0) and writing halt = 1 gives a stop condition (sdo 0 then 1). sclk_out and sclk_oe stay 1 throughout, and rx_data is not changed.
- R11: The control register takes ctl_wdata on ctl_wr and reads back on ctl_q. Bit 3 is halt, bit 2 is drive, and bits 1:0 are the source select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write data |
| ctl_q | output | 4 | Control register value |
| twowire_en | input | 1 | Two-wire condition mode when 1 |
| tx_load | input | 1 | Load the transmit buffer |
| tx_data | input | DATA_W | Transmit byte |
| tx_rdy | output | 1 | Transmit buffer holds an unsent byte |
| rx_data | output | DATA_W | Receive buffer |
| aux_tog2 | input | 1 | Timer-2 toggle clock source |
| aux_presc | input | 1 | Prescaler clock source |
| aux_tmr1 | input | 1 | Timer-1 clock source |
| sclk_in | input | 1 | Serial clock line, input side |
| sclk_out | output | 1 | Serial clock line, driven value |
| sclk_oe | output | 1 | Serial clock line output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The bench uses the defaults: DATA_W = 8 and COND_STEP = 2. With a two-cycle condition step, a whole start or stop waveform fits in a handful of samples. The three auxiliary sources are driven with rising edges every 3, 5 and 7 cycles. This makes the completion-latency window for each select code distinct from the others, so a wrong source choice shows up as a latency error rather than a hang. An 8-bit width keeps each transfer short enough to mix many random bytes and sources with directed aborts, external clocking and two-wire conditions.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  localparam int CTL_W = 4;

  typedef enum logic [1:0] {
    SRC_TOG2  = 2'b00,
    SRC_PRESC = 2'b01,
    SRC_TMR1  = 2'b10,
    SRC_SYS   = 2'b11
  } clk_src_e;

  typedef struct packed {
    logic     halt;
    logic     drive_clk;
    clk_src_e src;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{halt: 1'b1, drive_clk: 1'b1, src: SRC_SYS};

  // aux vector order: [0] timer-2 toggle, [1] prescaler, [2] timer-1
  function automatic logic aux_level(clk_src_e s, logic [2:0] v);
    case (s)
      SRC_TOG2:  return v[0];
      SRC_PRESC: return v[1];
      SRC_TMR1:  return v[2];
      default:   return 1'b0;
    endcase
  endfunction

  // one-cycle strobe per rising edge of the chosen source
  function automatic logic src_strobe(clk_src_e s, logic [2:0] now, logic [2:0] prev);
    if (s == SRC_SYS) return 1'b1;
    return aux_level(s, now) & ~aux_level(s, prev);
  endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen
  import ssp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_t       ctl,
  input  logic       run,
  input  logic [2:0] aux_src,
  input  logic       sclk_in,
  output logic       rise_ev,
  output logic       fall_ev,
  output logic       int_clk
);

  logic [2:0] aux_q;
  logic       sclk_q;
  logic       div_q;
  logic       strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      aux_q  <= aux_src;
      sclk_q <= sclk_in;
    end
  end

  always_comb strobe = src_strobe(ctl.src, aux_src, aux_q);

  // divide-by-2 toggle, cleared while halted or idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      div_q <= 1'b0;
    else if (ctl.halt || !run)       div_q <= 1'b0;
    else if (ctl.drive_clk && strobe) div_q <= ~div_q;
  end

  always_comb begin
    if (ctl.drive_clk) begin
      rise_ev = run & strobe & ~div_q;
      fall_ev = run & strobe &  div_q;
    end else begin
      rise_ev = run &  sclk_in & ~sclk_q;
      fall_ev = run & ~sclk_in &  sclk_q;
    end
  end

  assign int_clk = div_q;

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              allow,
  input  logic              abort,
  input  logic              copy_req,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              sdi,
  output logic              busy,
  output logic              tx_rdy,
  output logic              tx_msb,
  output logic [DATA_W-1:0] rx_data,
  output logic              done,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              launch
);

  logic [DATA_W-1:0] tx_buf;
  logic [DATA_W-1:0] shreg;
  logic              smp;
  logic              last_fall;

  function automatic logic [DATA_W-1:0] shift_in(logic [DATA_W-1:0] v, logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  assign launch    = !halt && tx_rdy && !busy && allow;
  assign last_fall = busy && fall_ev && !abort && (bit_cnt == CNT_W'(DATA_W - 1));
  assign tx_msb    = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      shreg   <= '0;
      smp     <= 1'b0;
      busy    <= 1'b0;
      tx_rdy  <= 1'b0;
      rx_data <= '0;
      done    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      done <= last_fall;
      if (tx_load) tx_buf <= tx_data;

      if (tx_load)        tx_rdy <= 1'b1;
      else if (last_fall) tx_rdy <= 1'b0;

      if (busy && rise_ev) smp <= sdi;

      if (abort)          busy <= 1'b0;
      else if (launch)    busy <= 1'b1;
      else if (last_fall) busy <= 1'b0;

      if (launch) begin
        shreg   <= tx_buf;
        bit_cnt <= '0;
      end else if (busy && fall_ev && !abort) begin
        shreg   <= shift_in(shreg, smp);
        bit_cnt <= last_fall ? '0 : bit_cnt + 1'b1;
      end

      if (copy_req)       rx_data <= shreg;
      else if (last_fall) rx_data <= shift_in(shreg, smp);
    end
  end

endmodule

// File: rtl/ssp_cond.sv
module ssp_cond #(
  parameter int COND_STEP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_start,
  input  logic req_stop,
  output logic active,
  output logic sda,
  output logic sda_idle
);

  localparam int SC_W = (COND_STEP > 1) ? $clog2(COND_STEP) : 1;

  logic            phase;
  logic            kind;   // 0 start, 1 stop
  logic [SC_W-1:0] step_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      phase    <= 1'b0;
      kind     <= 1'b0;
      step_cnt <= '0;
      sda_idle <= 1'b1;
    end else if (!active) begin
      if (req_start || req_stop) begin
        active   <= 1'b1;
        kind     <= req_stop;
        phase    <= 1'b0;
        step_cnt <= '0;
      end
    end else if (step_cnt == SC_W'(COND_STEP - 1)) begin
      step_cnt <= '0;
      if (phase) begin
        active   <= 1'b0;
        sda_idle <= kind;
      end else begin
        phase <= 1'b1;
      end
    end else begin
      step_cnt <= step_cnt + 1'b1;
    end
  end

  // first half holds the old level, second half the new one
  assign sda = phase ? kind : ~kind;

endmodule

// File: rtl/ssp_core.sv
module ssp_core
  import ssp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int COND_STEP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [3:0]        ctl_wdata,
  output logic [3:0]        ctl_q,
  input  logic              twowire_en,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_rdy,
  output logic [DATA_W-1:0] rx_data,
  input  logic              aux_tog2,
  input  logic              aux_presc,
  input  logic              aux_tmr1,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              sdi,
  output logic              sdo,
  output logic              xfer_done
);

  localparam int CNT_W = $clog2(DATA_W) + 1;

  ctl_t             ctl_r;
  logic             busy_w;
  logic             rise_ev;
  logic             fall_ev;
  logic             int_clk;
  logic             tx_msb;
  logic [CNT_W-1:0] bit_cnt;
  logic             launch;
  logic             cond_active;
  logic             cond_sda;
  logic             sda_idle;
  logic             halt_wr;
  logic             abort;
  logic             copy_req;
  logic             req_start;
  logic             req_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_r <= CTL_RESET;
    else if (ctl_wr) ctl_r <= ctl_t'(ctl_wdata);
  end
  assign ctl_q = ctl_r;

  assign halt_wr   = ctl_wr & ctl_wdata[3];
  assign abort     = halt_wr;
  assign copy_req  = halt_wr & ~twowire_en;
  assign req_start = ctl_wr & twowire_en & ~ctl_wdata[3];
  assign req_stop  = halt_wr & twowire_en;

  ssp_clkgen u_clkgen (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl_r),
    .run     (busy_w),
    .aux_src ({aux_tmr1, aux_presc, aux_tog2}),
    .sclk_in (sclk_in),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .int_clk (int_clk)
  );

  ssp_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (ctl_r.halt),
    .allow    (~cond_active),
    .abort    (abort),
    .copy_req (copy_req),
    .tx_load  (tx_load),
    .tx_data  (tx_data),
    .rise_ev  (rise_ev),
    .fall_ev  (fall_ev),
    .sdi      (sdi),
    .busy     (busy_w),
    .tx_rdy   (tx_rdy),
    .tx_msb   (tx_msb),
    .rx_data  (rx_data),
    .done     (xfer_done),
    .bit_cnt  (bit_cnt),
    .launch   (launch)
  );

  ssp_cond #(.COND_STEP(COND_STEP)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .req_stop  (req_stop),
    .active    (cond_active),
    .sda       (cond_sda),
    .sda_idle  (sda_idle)
  );

  always_comb begin
    if (cond_active)                    sclk_out = 1'b1;
    else if (busy_w && ctl_r.drive_clk) sclk_out = int_clk;
    else                                sclk_out = 1'b1;
  end

  assign sclk_oe = ctl_r.drive_clk | cond_active;

  always_comb begin
    if (cond_active) sdo = cond_sda;
    else if (busy_w) sdo = tx_msb;
    else             sdo = sda_idle;
  end

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             fall_ev,
  input logic             xfer_done,
  input logic             tx_rdy,
  input logic             tx_load,
  input logic             sdo,
  input logic             ctl_wr,
  input logic             halt,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             cond_active,
  input logic             sclk_out,
  input logic             sclk_oe
);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  // R5
  rdy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !$past(tx_load)) |-> !tx_rdy);

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(DATA_W));

  // R2
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !busy);

  // R3
  launch_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_rdy));

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_ev && !ctl_wr) |=> $stable(sdo));

  // R10
  cond_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_active |-> (sclk_out && sclk_oe));

  // R8
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_out);

endmodule

bind ssp_core ssp_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy_w),
  .fall_ev     (fall_ev),
  .xfer_done   (xfer_done),
  .tx_rdy      (tx_rdy),
  .tx_load     (tx_load),
  .sdo         (sdo),
  .ctl_wr      (ctl_wr),
  .halt        (ctl_q[3]),
  .bit_cnt     (bit_cnt),
  .cond_active (cond_active),
  .sclk_out    (sclk_out),
  .sclk_oe     (sclk_oe)
);

// File: tb/ssp_core_tb.sv
`timescale 1ns/1ps
module ssp_core_tb_top;

  localparam int DATA_W = 8;
  localparam int P_TOG2 = 3;
  localparam int P_PRESC = 5;
  localparam int P_TMR1 = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 1'b0;
  logic [3:0] ctl_wdata = '0;
  logic [3:0] ctl_q;
  logic twowire_en = 1'b0;
  logic tx_load = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic tx_rdy;
  logic [DATA_W-1:0] rx_data;
  logic aux_tog2 = 1'b0, aux_presc = 1'b0, aux_tmr1 = 1'b0;
  logic sclk_in = 1'b0;
  logic sclk_out, sclk_oe;
  logic sdi = 1'b0;
  logic sdo;
  logic xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  int c3 = 0, c5 = 0, c7 = 0;

  always #5 clk = ~clk;

  ssp_core #(.DATA_W(DATA_W), .COND_STEP(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .twowire_en(twowire_en), .tx_load(tx_load), .tx_data(tx_data), .tx_rdy(tx_rdy),
    .rx_data(rx_data), .aux_tog2(aux_tog2), .aux_presc(aux_presc), .aux_tmr1(aux_tmr1),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo),
    .xfer_done(xfer_done)
  );

  // auxiliary sources: one-cycle high pulse every P cycles
  always @(negedge clk) begin
    c3 <= (c3 == P_TOG2 - 1) ? 0 : c3 + 1;
    c5 <= (c5 == P_PRESC - 1) ? 0 : c5 + 1;
    c7 <= (c7 == P_TMR1 - 1) ? 0 : c7 + 1;
    aux_tog2  <= (c3 == 0);
    aux_presc <= (c5 == 0);
    aux_tmr1  <= (c7 == 0);
  end

  function automatic int src_period(input logic [1:0] sel);
    case (sel)
      2'b11: return 1;
      2'b10: return P_TMR1;
      2'b01: return P_PRESC;
      default: return P_TOG2;
    endcase
  endfunction

  // done lands between the first strobe after launch + 15 periods
  function automatic int lat_lo(input logic [1:0] sel);
    return 15 * src_period(sel) + 2;
  endfunction
  function automatic int lat_hi(input logic [1:0] sel);
    return 16 * src_period(sel) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ctl_wr = 1'b0; tx_load = 1'b0; sclk_in = 1'b0; sdi = 1'b0; twowire_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [3:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic load_tx(input logic [7:0] d);
    tx_data = d; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic int_xfer(input logic [1:0] sel, input logic [7:0] txd, input logic [7:0] rxd);
    int lat = 0;
    int rises = 0;
    logic prev;
    logic [7:0] got = '0;
    bit seen = 0;
    wr_ctl({2'b01, sel});
    sdi = rxd[7];
    load_tx(txd);
    prev = sclk_out;
    while (!seen && lat < 4000) begin
      @(negedge clk);
      lat++;
      if (xfer_done) seen = 1;
      else if (sclk_out && !prev) begin
        got[7 - rises] = sdo;
        rises++;
        if (rises < 8) sdi = rxd[7 - rises];
      end
      prev = sclk_out;
    end
    chk(seen, "R5 done seen", seen, 1);
    if (sel == 2'b11) chk(lat == 17, "R6 sysclk latency", lat, 17);
    else chk(lat >= lat_lo(sel) && lat <= lat_hi(sel), "R6 source latency", lat, lat_lo(sel));
    chk(rises == 8, "R5 eight clocks", rises, 8);
    chk(got == txd, "R4 msb-first tx", got, txd);
    chk(rx_data == rxd, "R4 rx byte", rx_data, rxd);
    chk(tx_rdy == 1'b0, "R5 tx_rdy cleared", tx_rdy, 0);
    @(negedge clk);
    chk(xfer_done == 1'b0, "R5 done one cycle", xfer_done, 0);
  endtask

  task automatic ext_bits(input logic [7:0] txd, input logic [7:0] rxd, input int n, output int dones);
    dones = 0;
    for (int k = 0; k < n; k++) begin
      sdi = rxd[7 - k];
      chk(sdo == txd[7 - k], "R4 sdo before rise", sdo, txd[7 - k]);
      sclk_in = 1'b1;
      repeat (2) begin @(negedge clk); if (xfer_done) dones++; end
      sclk_in = 1'b0;
      repeat (2) begin @(negedge clk); if (xfer_done) dones++; end
    end
  endtask

  task automatic watch_cond(input logic kind);
    bit clk_ok = 1;
    bit edge_seen = 0;
    logic first;
    logic prev;
    first = sdo;
    prev = sdo;
    for (int i = 0; i < 6; i++) begin
      if (i < 4 && !(sclk_out && sclk_oe)) clk_ok = 0;
      if (sdo == kind && prev == ~kind) edge_seen = 1;
      prev = sdo;
      @(negedge clk);
    end
    chk(first == ~kind, "R10 condition first level", first, ~kind);
    chk(edge_seen, "R10 data edge while clock high", edge_seen, 1);
    chk(clk_ok, "R10 clock held high", clk_ok, 1);
    chk(sdo == kind, "R10 condition final level", sdo, kind);
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int dones;
    bit bad;
    int unsigned seed;
    logic [7:0] rx_prev;
    seed = $urandom(32'h5eed);

    do_reset();
    // R1 reset state
    chk(ctl_q == 4'hF, "R1 ctl reset", ctl_q, 4'hF);
    chk(tx_rdy == 1'b0, "R1 tx_rdy reset", tx_rdy, 0);
    chk(rx_data == 8'h00, "R1 rx reset", rx_data, 0);
    chk(sdo && sclk_out && sclk_oe, "R1 line levels", {sdo, sclk_out, sclk_oe}, 3'b111);
    chk(xfer_done == 1'b0, "R1 done reset", xfer_done, 0);

    // R2 halted port does nothing
    load_tx(8'hC3);
    chk(tx_rdy == 1'b1, "R3 load sets tx_rdy", tx_rdy, 1);
    bad = 0;
    repeat (40) begin
      @(negedge clk);
      if (!sclk_out || xfer_done || !sdo) bad = 1;
    end
    chk(!bad, "R2 no activity while halted", bad, 0);
    chk(tx_rdy == 1'b1, "R2 tx_rdy kept", tx_rdy, 1);

    // R11 control layout
    do_reset();
    wr_ctl(4'b1010);
    chk(ctl_q == 4'b1010, "R11 ctl readback", ctl_q, 4'b1010);

    // R6 directed sources
    int_xfer(2'b11, 8'hA5, 8'h3C);
    int_xfer(2'b10, 8'h81, 8'h7E);
    int_xfer(2'b01, 8'h0F, 8'hF0);
    int_xfer(2'b00, 8'hFF, 8'h00);

    // random sources and data
    for (int i = 0; i < 8; i++) begin
      int_xfer(2'($urandom), 8'($urandom), 8'($urandom));
    end

    // R8 idle line driven high
    repeat (5) @(negedge clk);
    chk(sclk_oe && sclk_out, "R8 idle clock high and driven", {sclk_oe, sclk_out}, 2'b11);

    // R7 external clock, select ignored
    do_reset();
    wr_ctl(4'b0011);
    chk(sclk_oe == 1'b0, "R7 line released", sclk_oe, 0);
    load_tx(8'h96);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      if (xfer_done) bad = 1;
    end
    chk(!bad, "R7 no shift without sclk_in", bad, 0);
    ext_bits(8'h96, 8'h69, 8, dones);
    chk(dones == 1, "R5 single done pulse", dones, 1);
    chk(rx_data == 8'h69, "R7 external rx byte", rx_data, 8'h69);
    chk(tx_rdy == 1'b0, "R5 tx_rdy cleared ext", tx_rdy, 0);

    // R9 abort copies partial shift register
    load_tx(8'hE1);
    repeat (3) @(negedge clk);
    ext_bits(8'hE1, 8'hB4, 3, dones);
    wr_ctl(4'b1011);
    chk(rx_data == {5'(8'hE1), 3'b101}, "R9 copy on halt", rx_data, {5'(8'hE1), 3'b101});
    chk(dones == 0, "R9 no done on abort", dones, 0);

    // R10 two-wire conditions
    do_reset();
    twowire_en = 1'b1;
    wr_ctl(4'b0011);
    watch_cond(1'b0);
    load_tx(8'h5A);
    repeat (4) @(negedge clk);
    ext_bits(8'h5A, 8'hC6, 8, dones);
    chk(rx_data == 8'hC6, "R10 rx after two-wire transfer", rx_data, 8'hC6);
    rx_prev = rx_data;
    load_tx(8'h33);
    repeat (3) @(negedge clk);
    ext_bits(8'h33, 8'h0F, 3, dones);
    wr_ctl(4'b1011);
    watch_cond(1'b1);
    chk(rx_data == rx_prev, "R10 no copy in two-wire", rx_data, rx_prev);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule